// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. There are three sources: an external request pin, a one-cycle overflow pulse from a timer, and a change on a 4-bit group of port pins. Each source has its own sticky flag and its own enable bit. A global enable bit governs all three. Flags, enables and the global enable sit in one 8-bit control register. Software reads and writes this register over a simple register bus.

When the global enable is set and at least one flag is pending with its enable set, the controller offers a vector to the core's sequencer on a valid/ready pair. The vector address is fixed at 0004h. The handshake completes in a cycle where `vec_valid` and `core_ready` are both high. In that cycle `push_req` tells the sequencer to save the return address. On the next edge the global enable clears. Back-pressure rule: while `core_ready` is low, `vec_valid` stays asserted and nothing else happens.

Flags are never cleared by the hardware. Software clears them by writing zeros. A separate `wake` output shows any enabled pending request, whatever the global enable, so the core can leave sleep. A return-from-interrupt pulse sets the global enable again.

Top module: `trio_irq_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 00h and both `vec_valid` and `wake` are low.
- R2: The control register layout is: bit 7 global enable, bit 6 change-enable, bit 5 timer-enable, bit 4 pin-enable, bit 3 always reads 0, bit 2 change-flag, bit 1 timer-flag, bit 0 pin-flag. A write with `reg_wr_en` stores bits 7:4 and 2:0, and the new value is readable on the next cycle.
- R3: A `tmr_ovf` pulse sets the timer flag (bit 1) on the next clock edge, whatever its enable bit holds.
- R4: The request pin passes through a two-stage synchronizer. When `ext_rise_sel`=1, a rising edge sets bit 0; when it is 0, a falling edge sets bit 0. The flag is set within four cycles of the pin change. An edge of the other polarity leaves bit 0 unchanged.
- R5: Bit 2 is set whenever the synchronized `port_pins` differ from a snapshot that is captured on each `port_rd` pulse. Once a read has captured the current pins, clearing the flag keeps it clear.
- R6: `vec_valid` equals (global enable AND any flag ANDed with its enable), and `vec_addr` is 0004h.
- R7: In a cycle with `vec_valid` and `core_ready` both high, `push_req` is high. After that edge the global enable reads 0, `vec_valid` drops, and the flags are unchanged.
- R8: While `vec_valid` is high and `core_ready` is low, `push_req` stays low and `vec_valid` stays high.
- R9: `wake` is high whenever any flag is set together with its enable, including when the global enable is 0.
- R10: A `ret_irq` pulse sets the global enable on the next edge. If an acceptance happens in the same cycle, the acceptance wins and the enable clears.
- R11: When a hardware event and a software write that clears the same flag fall on the same edge, the flag ends up set.
- R12: The hardware never clears a flag. Without a register write, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ext_pin | input | 1 | Asynchronous external request pin |
| ext_rise_sel | input | 1 | 1 = rising edge, 0 = falling edge on ext_pin |
| tmr_ovf | input | 1 | Timer overflow pulse (synchronous) |
| port_pins | input | 4 | Asynchronous upper port pins watched for change |
| port_rd | input | 1 | Port read strobe; captures the change snapshot |
| core_ready | input | 1 | Sequencer can accept a vector |
| ret_irq | input | 1 | Return-from-interrupt indication |
| vec_valid | output | 1 | Vector request pending |
| vec_addr | output | 16 | Vector address (0004h) |
| push_req | output | 1 | Push return address (handshake cycle) |
| wake | output | 1 | Enabled request pending, leave sleep |

## Verification
A corrupt flag or enable bit shows up directly in `reg_rdata` on the cycle after the event. Through the combinational request logic it also appears on `vec_valid` and `wake` in that same cycle. For this reason the bench sweeps every combination of flags, enables and global enable and compares both outputs at once. A global enable that fails to clear after acceptance shows on the next cycle as a second `push_req` or a `vec_valid` that stays high. A wrong edge polarity or a stale port snapshot only shows after the three to four cycles of synchronizer latency.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int NSRC      = 3;
  localparam int SRC_PIN   = 0;
  localparam int SRC_TMR   = 1;
  localparam int SRC_CHG   = 2;
  localparam int EN_LSB    = 4;
  localparam int GIE_BIT   = 7;
  localparam int REG_W     = 8;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq3_sync.sv
module irq3_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq3_detect.sv
module irq3_detect
  import irq3_pkg::*;
#(
  parameter int CHG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s,
  input  logic             rise_sel,
  input  logic             tmr_ovf,
  input  logic [CHG_W-1:0] pins_s,
  input  logic             port_rd,
  output src_vec_t         hit
);
  logic             pin_d;
  logic [CHG_W-1:0] snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_d <= 1'b0;
      snap  <= '0;
    end else begin
      pin_d <= pin_s;
      if (port_rd) snap <= pins_s;
    end
  end

  always_comb begin
    hit          = '0;
    hit[SRC_PIN] = rise_sel ? (pin_s & ~pin_d) : (~pin_s & pin_d);
    hit[SRC_TMR] = tmr_ovf;
    hit[SRC_CHG] = (pins_s != snap);
  end
endmodule

// File: rtl/irq3_regs.sv
module irq3_regs
  import irq3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  src_vec_t         hit,
  input  logic             accept,
  input  logic             ret_irq,
  output src_vec_t         flags,
  output src_vec_t         en,
  output logic             gie,
  output logic [REG_W-1:0] rdata
);
  src_vec_t flags_base;

  always_comb begin
    flags_base = wr_en ? wdata[NSRC-1:0] : flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      gie   <= 1'b0;
    end else begin
      flags <= flags_base | hit;
      if (wr_en) en <= wdata[EN_LSB +: NSRC];
      if (accept)       gie <= 1'b0;
      else if (ret_irq) gie <= 1'b1;
      else if (wr_en)   gie <= wdata[GIE_BIT];
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[NSRC-1:0]       = flags;
    rdata[EN_LSB +: NSRC] = en;
    rdata[GIE_BIT]        = gie;
  end
endmodule

// File: rtl/trio_irq_ctrl.sv
module trio_irq_ctrl
  import irq3_pkg::*;
#(
  parameter int          CHG_W       = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VEC_ADDR    = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ext_pin,
  input  logic              ext_rise_sel,
  input  logic              tmr_ovf,
  input  logic [CHG_W-1:0]  port_pins,
  input  logic              port_rd,
  input  logic              core_ready,
  input  logic              ret_irq,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              push_req,
  output logic              wake
);
  localparam int SYNC_W = CHG_W + 1;

  logic [SYNC_W-1:0] raw_in, sync_out;
  src_vec_t          hit, flags, en;
  logic              gie, accept, pending;

  assign raw_in = {port_pins, ext_pin};

  irq3_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  irq3_detect #(.CHG_W(CHG_W)) det_i (
    .clk(clk), .rst_n(rst_n), .pin_s(sync_out[0]), .rise_sel(ext_rise_sel),
    .tmr_ovf(tmr_ovf), .pins_s(sync_out[SYNC_W-1:1]), .port_rd(port_rd),
    .hit(hit)
  );

  irq3_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .hit(hit), .accept(accept), .ret_irq(ret_irq), .flags(flags),
    .en(en), .gie(gie), .rdata(reg_rdata)
  );

  assign pending   = |(flags & en);
  assign wake      = pending;
  assign vec_valid = gie & pending;
  assign accept    = vec_valid & core_ready;
  assign push_req  = accept;
  assign vec_addr  = VEC_ADDR[ADDR_W-1:0];
endmodule

// File: rtl/irq3_chk.sv
module irq3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [7:0]  reg_rdata,
  input logic        tmr_ovf,
  input logic        core_ready,
  input logic        ret_irq,
  input logic        vec_valid,
  input logic        push_req,
  input logic        wake
);
  // R3
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_rdata[1]);
  // R7
  accept_gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && core_ready) |=> !reg_rdata[7]);
  // R7
  push_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !vec_valid);
  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !core_ready && !reg_wr_en) |=> vec_valid);
  // R9
  wake_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> wake);
  // R10
  ret_gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_irq && !(vec_valid && core_ready)) |=> reg_rdata[7]);
  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> ((reg_rdata[2:0] & $past(reg_rdata[2:0])) == $past(reg_rdata[2:0])));
endmodule

bind trio_irq_ctrl irq3_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata),
  .tmr_ovf(tmr_ovf), .core_ready(core_ready), .ret_irq(ret_irq),
  .vec_valid(vec_valid), .push_req(push_req), .wake(wake)
);

// File: tb/trio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module trio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ext_pin = 1'b0;
  logic        ext_rise_sel = 1'b1;
  logic        tmr_ovf = 1'b0;
  logic [3:0]  port_pins = '0;
  logic        port_rd = 1'b0;
  logic        core_ready = 1'b0;
  logic        ret_irq = 1'b0;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic        push_req;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel),
    .tmr_ovf(tmr_ovf), .port_pins(port_pins), .port_rd(port_rd),
    .core_ready(core_ready), .ret_irq(ret_irq), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .push_req(push_req), .wake(wake)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    cyc(1);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 rdata", {8'h0, reg_rdata}, 16'h0000);
    check("R1 vec_valid", {15'h0, vec_valid}, 16'h0000);
    check("R1 wake", {15'h0, wake}, 16'h0000);
    check("R6 vec_addr", vec_addr, 16'h0004);

    // R2 R6 R9: sweep global enable, enables and flags
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 8; e++) begin
        for (int f = 0; f < 8; f++) begin
          logic [7:0] v;
          logic any;
          v = {g[0], e[2:0], 1'b0, f[2:0]};
          any = |(e[2:0] & f[2:0]);
          wr(v | 8'h08);
          check("R2 readback", {8'h0, reg_rdata}, {8'h0, v});
          check("R6 vec_valid", {15'h0, vec_valid}, {15'h0, g[0] & any});
          check("R9 wake", {15'h0, wake}, {15'h0, any});
        end
      end
    end
    wr(8'h00);

    // R3 timer flag set with enable off
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    check("R3 tmr flag", {8'h0, reg_rdata}, 16'h0002);
    check("R9 no wake when disabled", {15'h0, wake}, 16'h0000);

    // R11 hardware set beats software clear
    wr(8'h02);
    tmr_ovf = 1'b1; reg_wr_en = 1'b1; reg_wdata = 8'h00;
    cyc(1);
    tmr_ovf = 1'b0; reg_wr_en = 1'b0;
    check("R11 set wins", {8'h0, reg_rdata}, 16'h0002);

    // R8 back-pressure, R7 acceptance
    wr(8'hA0);
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    check("R6 valid after flag", {15'h0, vec_valid}, 16'h0001);
    check("R8 no push", {15'h0, push_req}, 16'h0000);
    cyc(3);
    check("R8 held", {15'h0, vec_valid}, 16'h0001);
    core_ready = 1'b1; #1;
    check("R7 push", {15'h0, push_req}, 16'h0001);
    cyc(1); core_ready = 1'b0;
    check("R7 gie clear, flags kept", {8'h0, reg_rdata}, 16'h0022);
    check("R7 valid drop", {15'h0, vec_valid}, 16'h0000);
    check("R9 wake with gie off", {15'h0, wake}, 16'h0001);
    cyc(4);
    check("R12 flag sticky", {8'h0, reg_rdata}, 16'h0022);

    // R10 return sets gie; same-cycle acceptance wins
    ret_irq = 1'b1; cyc(1); ret_irq = 1'b0;
    check("R10 gie set", {8'h0, reg_rdata}, 16'h00A2);
    ret_irq = 1'b1; core_ready = 1'b1; cyc(1); ret_irq = 1'b0; core_ready = 1'b0;
    check("R10 accept wins", {8'h0, reg_rdata}, 16'h0022);
    wr(8'h00);

    // R4 rising edge selected
    ext_rise_sel = 1'b1;
    ext_pin = 1'b1; cyc(4);
    check("R4 rise sets", {8'h0, reg_rdata}, 16'h0001);
    wr(8'h00);
    ext_pin = 1'b0; cyc(4);
    check("R4 fall ignored", {8'h0, reg_rdata}, 16'h0000);
    // R4 falling edge selected
    ext_rise_sel = 1'b0;
    ext_pin = 1'b1; cyc(4);
    check("R4 rise ignored", {8'h0, reg_rdata}, 16'h0000);
    ext_pin = 1'b0; cyc(4);
    check("R4 fall sets", {8'h0, reg_rdata}, 16'h0001);
    wr(8'h00);

    // R5 port change and snapshot on read
    for (int p = 1; p < 16; p += 5) begin
      port_pins = p[3:0]; cyc(4);
      check("R5 change sets", {8'h0, reg_rdata}, 16'h0004);
      port_rd = 1'b1; cyc(1); port_rd = 1'b0;
      wr(8'h00); cyc(3);
      check("R5 stays clear after read", {8'h0, reg_rdata}, 16'h0000);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule